// File: doc/BRIEF.md
# Display Controller Command Decoder

This block sits behind the host interface of a character display controller. Each cycle it may receive one byte, with a flag that marks the byte as a command or as display data. It decodes command bytes into the controller's control state: four display flags, three power flags, four system setup bits and a 7-bit address counter. A data byte becomes a single-cycle write request to an external memory port at the current counter value, and the counter then advances by one.

One address map is shared by every memory behind the port: the character RAM, the line buffers and the symbol and static registers. The counter therefore walks across all of them and wraps from the top of the map back to zero. The cursor position comes straight from the exported counter. A home command presets the counter to 30H, which is the first cell of the first text line. The memories, glyph generation and panel waveform timing are outside this block.

Top module: `dispctl_cmd_decode`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, every display, power and setup flag reads 0, `addr_cnt` reads 00H and `wr_en` reads 0.
- R2: Command bytes whose top nibble is 0H (no-operation 00H and the test codes 01H–0FH), 2H or 7H change no flag and do not change `addr_cnt`, and they raise no `wr_en`.
- R3: A command byte with top nibble 1H loads `addr_cnt` with 30H on the next clock edge. The low nibble is ignored.
- R4: A command byte 3H in the top nibble with bits [3:0] = {C,B,H,D} sets `cursor_on`=C, `blink_on`=B, `dbl_height`=H and `disp_on`=D. All other state is left as it was.
- R5: A command byte 4H in the top nibble sets `osc_on` from bit 1 and `pwr_save` from bit 0. All other state is left as it was.
- R6: A command byte 5H in the top nibble sets `pwr_circ_on` from bit 0. Bits 3:1 and all other state are left as they were.
- R7: A command byte 6H in the top nibble sets `two_line` from bit 3, `mirror_h` from bit 2, `mirror_v` from bit 1 and `ucg_en` from bit 0. All other state is left as it was.
- R8: A command byte with bit 7 set loads bits 6:0 into `addr_cnt` on the next clock edge. Every value from 00H to 7FH can be loaded.
- R9: On the cycle after a data byte is accepted, `wr_en` is 1, `wr_addr` equals the counter value before the write and `wr_data` equals the byte. In the same cycle `addr_cnt` reads that value plus one. Flags are unchanged.
- R10: A data write at counter 7FH leaves `addr_cnt` at 00H.
- R11: With `in_valid` low, no state changes and `wr_en` stays 0, whatever `in_is_data` and `in_byte` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_is_data | input | 1 | 1: display data, 0: command |
| in_byte | input | 8 | Command or data byte |
| wr_en | output | 1 | One-cycle memory write request |
| wr_addr | output | 7 | Address of the write request |
| wr_data | output | 8 | Data of the write request |
| addr_cnt | output | 7 | Current address counter (cursor position) |
| cursor_on | output | 1 | Cursor shown |
| blink_on | output | 1 | Cursor blinking |
| dbl_height | output | 1 | Double-height text |
| disp_on | output | 1 | Display enabled |
| osc_on | output | 1 | Oscillator running |
| pwr_save | output | 1 | Power-save selected |
| pwr_circ_on | output | 1 | Drive power circuit enabled |
| two_line | output | 1 | 1: two text lines, 0: three |
| mirror_h | output | 1 | Left-right reversal |
| mirror_v | output | 1 | Top-bottom reversal |
| ucg_en | output | 1 | User character RAM selected for codes 0–3 |

## Verification
All 256 command byte values are swept. Before each one, the bench loads a distinct mix of flags and counter values, derived from the byte under test. This shows that each opcode touches only its own fields, and that ignored codes leave set bits and cleared bits alike as they were. A run of data writes starting at 70H crosses 7FH. It separates correct wrapping and the pre-increment write address from off-by-one errors. Idle cycles with garbage on the byte and data-flag inputs confirm that nothing happens without `in_valid`.

// File: rtl/dispctl_pkg.sv
`timescale 1ns/1ps
// Shared types for the display controller command decoder.
// Assumes an 8-bit host byte whose top bit marks an address load.
package dispctl_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_HOME  = 3'd1,
        OP_DISP  = 3'd2,
        OP_PSAVE = 3'd3,
        OP_PCTL  = 3'd4,
        OP_SETUP = 3'd5,
        OP_ALOAD = 3'd6,
        OP_DATA  = 3'd7
    } op_e;

    typedef struct packed {
        logic cursor;
        logic blink;
        logic dbl;
        logic on;
    } disp_flags_t;

    typedef struct packed {
        logic osc;
        logic save;
        logic circ;
    } pwr_flags_t;

    typedef struct packed {
        logic two_line;
        logic mirror_h;
        logic mirror_v;
        logic ucg;
    } setup_t;

endpackage

// File: rtl/dispctl_op_classify.sv
`timescale 1ns/1ps
// Classifies an incoming host byte into one operation.
// Purely combinational. Assumes bit DATA_W-1 is the address-load prefix
// and the three bits below it select the command group.
module dispctl_op_classify
    import dispctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              in_valid,
    input  logic              in_is_data,
    input  logic [DATA_W-1:0] in_byte,
    output op_e               op
);
    localparam int GRP_HI = DATA_W - 2;

    logic [2:0] grp;
    assign grp = in_byte[GRP_HI -: 3];

    // Map valid/flag/prefix/group to a single operation code.
    always_comb begin
        op = OP_NONE;
        if (in_valid) begin
            if (in_is_data) begin
                op = OP_DATA;
            end else if (in_byte[DATA_W-1]) begin
                op = OP_ALOAD;
            end else begin
                case (grp)
                    3'b001:  op = OP_HOME;
                    3'b011:  op = OP_DISP;
                    3'b100:  op = OP_PSAVE;
                    3'b101:  op = OP_PCTL;
                    3'b110:  op = OP_SETUP;
                    default: op = OP_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/dispctl_ctrl_regs.sv
`timescale 1ns/1ps
// Holds the display, power and setup flags.
// Assumes the payload is the low nibble of a command byte. Every flag
// clears on synchronous active-low reset.
module dispctl_ctrl_regs
    import dispctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  op_e         op,
    input  logic [3:0]  payload,
    output disp_flags_t disp_q,
    output pwr_flags_t  pwr_q,
    output setup_t      setup_q
);
    // Display flags: written only by the display-control group.
    always_ff @(posedge clk) begin
        if (!rst_n)              disp_q <= '0;
        else if (op == OP_DISP)  disp_q <= payload;
    end

    // Power flags: oscillator/save and circuit come from two groups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q <= '0;
        end else if (op == OP_PSAVE) begin
            pwr_q.osc  <= payload[1];
            pwr_q.save <= payload[0];
        end else if (op == OP_PCTL) begin
            pwr_q.circ <= payload[0];
        end
    end

    // System setup bits: written only by the setup group.
    always_ff @(posedge clk) begin
        if (!rst_n)              setup_q <= '0;
        else if (op == OP_SETUP) setup_q <= payload;
    end
endmodule

// File: rtl/dispctl_addr_ctr.sv
`timescale 1ns/1ps
// Address counter and memory write request register.
// Assumes one map for all memories. The counter wraps at the top,
// and a write goes out at the pre-increment address.
module dispctl_addr_ctr
    import dispctl_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] HOME_ADDR = 7'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [DATA_W-1:0] in_byte,
    output logic [ADDR_W-1:0] count_q,
    output logic              wr_en_q,
    output logic [ADDR_W-1:0] wr_addr_q,
    output logic [DATA_W-1:0] wr_data_q
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    // Counter: home preset, direct load or step after a data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            case (op)
                OP_HOME:  count_q <= HOME_ADDR;
                OP_ALOAD: count_q <= in_byte[ADDR_W-1:0];
                OP_DATA:  count_q <= count_q + ONE;
                default:  count_q <= count_q;
            endcase
        end
    end

    // Write request: one-cycle strobe with captured address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= (op == OP_DATA);
            if (op == OP_DATA) begin
                wr_addr_q <= count_q;
                wr_data_q <= in_byte;
            end
        end
    end
endmodule

// File: rtl/dispctl_cmd_decode.sv
`timescale 1ns/1ps
// Top of the display controller command decoder.
// Accepts one byte per cycle with a data/command flag, decodes commands
// into control flags and an address counter, and turns data bytes into
// memory write requests. Assumes DATA_W == ADDR_W + 1.
module dispctl_cmd_decode
    import dispctl_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] HOME_ADDR = 7'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_is_data,
    input  logic [DATA_W-1:0] in_byte,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] addr_cnt,
    output logic              cursor_on,
    output logic              blink_on,
    output logic              dbl_height,
    output logic              disp_on,
    output logic              osc_on,
    output logic              pwr_save,
    output logic              pwr_circ_on,
    output logic              two_line,
    output logic              mirror_h,
    output logic              mirror_v,
    output logic              ucg_en
);
    op_e         op;
    disp_flags_t disp_q;
    pwr_flags_t  pwr_q;
    setup_t      setup_q;

    dispctl_op_classify #(.DATA_W(DATA_W)) u_classify (
        .in_valid   (in_valid),
        .in_is_data (in_is_data),
        .in_byte    (in_byte),
        .op         (op)
    );

    dispctl_ctrl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .payload (in_byte[3:0]),
        .disp_q  (disp_q),
        .pwr_q   (pwr_q),
        .setup_q (setup_q)
    );

    dispctl_addr_ctr #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .HOME_ADDR (HOME_ADDR)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .in_byte   (in_byte),
        .count_q   (addr_cnt),
        .wr_en_q   (wr_en),
        .wr_addr_q (wr_addr),
        .wr_data_q (wr_data)
    );

    assign cursor_on   = disp_q.cursor;
    assign blink_on    = disp_q.blink;
    assign dbl_height  = disp_q.dbl;
    assign disp_on     = disp_q.on;
    assign osc_on      = pwr_q.osc;
    assign pwr_save    = pwr_q.save;
    assign pwr_circ_on = pwr_q.circ;
    assign two_line    = setup_q.two_line;
    assign mirror_h    = setup_q.mirror_h;
    assign mirror_v    = setup_q.mirror_v;
    assign ucg_en      = setup_q.ucg;
endmodule

// File: rtl/dispctl_cmd_decode_chk.sv
`timescale 1ns/1ps
// Port-level protocol checker for dispctl_cmd_decode, attached by bind.
// Assumes the default 8-bit byte and 7-bit counter layout.
module dispctl_cmd_decode_chk #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] HOME_ADDR = 7'h30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_is_data,
    input logic [DATA_W-1:0] in_byte,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] addr_cnt,
    input logic              cursor_on,
    input logic              blink_on,
    input logic              dbl_height,
    input logic              disp_on,
    input logic              osc_on,
    input logic              pwr_save,
    input logic              pwr_circ_on,
    input logic              two_line,
    input logic              mirror_h,
    input logic              mirror_v,
    input logic              ucg_en
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [10:0] flags;
    logic        is_cmd;
    logic [2:0]  grp;
    assign flags  = {cursor_on, blink_on, dbl_height, disp_on, osc_on, pwr_save,
                     pwr_circ_on, two_line, mirror_h, mirror_v, ucg_en};
    assign is_cmd = in_valid && !in_is_data && !in_byte[DATA_W-1];
    assign grp    = in_byte[DATA_W-2 -: 3];

    AST_IGNORED_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd && (grp == 3'd0 || grp == 3'd2 || grp == 3'd7)
        |=> $stable(flags) && $stable(addr_cnt) && !wr_en); // R2

    AST_HOME_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd && grp == 3'd1 |=> addr_cnt == HOME_ADDR); // R3

    AST_DISP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd && grp == 3'd3
        |=> {cursor_on, blink_on, dbl_height, disp_on} == $past(in_byte[3:0])); // R4

    AST_SETUP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd && grp == 3'd6
        |=> {two_line, mirror_h, mirror_v, ucg_en} == $past(in_byte[3:0])); // R7

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_is_data && in_byte[DATA_W-1]
        |=> addr_cnt == $past(in_byte[ADDR_W-1:0])); // R8

    AST_WRITE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_is_data
        |=> wr_en && wr_addr == $past(addr_cnt) && wr_data == $past(in_byte)
            && $stable(flags)); // R9

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_is_data
        |=> addr_cnt == ADDR_W'($past(addr_cnt) + ONE)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(flags) && $stable(addr_cnt) && !wr_en); // R11
endmodule

bind dispctl_cmd_decode dispctl_cmd_decode_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .HOME_ADDR (HOME_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_is_data  (in_is_data),
    .in_byte     (in_byte),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .addr_cnt    (addr_cnt),
    .cursor_on   (cursor_on),
    .blink_on    (blink_on),
    .dbl_height  (dbl_height),
    .disp_on     (disp_on),
    .osc_on      (osc_on),
    .pwr_save    (pwr_save),
    .pwr_circ_on (pwr_circ_on),
    .two_line    (two_line),
    .mirror_h    (mirror_h),
    .mirror_v    (mirror_v),
    .ucg_en      (ucg_en)
);

// File: tb/dispctl_cmd_decode_tb.sv
`timescale 1ns/1ps
// Self-checking bench: full command sweep from varied prior states,
// a data run across the counter wrap, idle cycles and reset.
module dispctl_cmd_decode_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_is_data = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       wr_en;
    logic [6:0] wr_addr;
    logic [7:0] wr_data;
    logic [6:0] addr_cnt;
    logic cursor_on, blink_on, dbl_height, disp_on, osc_on, pwr_save;
    logic pwr_circ_on, two_line, mirror_h, mirror_v, ucg_en;

    int checks = 0;
    int errors = 0;

    // expected state
    logic [6:0] e_addr = '0;
    logic [3:0] e_disp = '0;   // cursor, blink, dbl, on
    logic [1:0] e_ps   = '0;   // osc, save
    logic       e_pc   = 1'b0;
    logic [3:0] e_set  = '0;   // two_line, mirror_h, mirror_v, ucg
    logic       e_wr   = 1'b0;
    logic [6:0] e_waddr = '0;
    logic [7:0] e_wdata = '0;

    always #2 clk = ~clk;

    dispctl_cmd_decode u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_data(in_is_data),
        .in_byte(in_byte), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .addr_cnt(addr_cnt), .cursor_on(cursor_on), .blink_on(blink_on),
        .dbl_height(dbl_height), .disp_on(disp_on), .osc_on(osc_on),
        .pwr_save(pwr_save), .pwr_circ_on(pwr_circ_on), .two_line(two_line),
        .mirror_h(mirror_h), .mirror_v(mirror_v), .ucg_en(ucg_en)
    );

    function automatic string req_of(input logic d, input logic [7:0] b);
        if (d) return "R9";
        if (b[7]) return "R8";
        case (b[6:4])
            3'd1: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R2";
        endcase
    endfunction

    // Expected effect of one accepted byte, taken from the requirements.
    task automatic model(input logic d, input logic [7:0] b);
        e_wr = 1'b0;
        if (d) begin
            e_wr = 1'b1; e_waddr = e_addr; e_wdata = b;
            e_addr = e_addr + 7'd1;
        end else if (b[7]) begin
            e_addr = b[6:0];
        end else begin
            case (b[6:4])
                3'd1: e_addr = 7'h30;
                3'd3: e_disp = b[3:0];
                3'd4: e_ps   = b[1:0];
                3'd5: e_pc   = b[0];
                3'd6: e_set  = b[3:0];
                default: ;
            endcase
        end
    endtask

    task automatic check(input string req);
        logic [18:0] act, exp;
        act = {wr_en, addr_cnt, cursor_on, blink_on, dbl_height, disp_on,
               osc_on, pwr_save, pwr_circ_on, two_line, mirror_h, mirror_v, ucg_en};
        exp = {e_wr, e_addr, e_disp, e_ps, e_pc, e_set};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s state actual=%h expected=%h", req, act, exp);
        end
        if (e_wr) begin
            checks++;
            if ({wr_addr, wr_data} !== {e_waddr, e_wdata}) begin
                errors++;
                $display("FAIL %s write actual=%h/%h expected=%h/%h",
                         req, wr_addr, wr_data, e_waddr, e_wdata);
            end
        end
    endtask

    // Present one byte for one cycle, then check at the next falling edge.
    task automatic send(input logic d, input logic [7:0] b, input logic do_check);
        in_valid = 1'b1; in_is_data = d; in_byte = b;
        @(negedge clk);
        in_valid = 1'b0; in_is_data = 1'b0; in_byte = 8'h00;
        model(d, b);
        if (do_check) check(req_of(d, b));
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, including the cycle after release
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R2..R8: every command byte from a varied prior state
        for (int b = 0; b < 256; b++) begin
            send(1'b0, 8'h30 | 8'((b + 5) & 15), 1'b0);
            send(1'b0, 8'h40 | 8'((b >> 1) & 3), 1'b0);
            send(1'b0, 8'h50 | 8'((b >> 3) & 1), 1'b0);
            send(1'b0, 8'h60 | 8'(~b & 15), 1'b0);
            send(1'b0, 8'h80 | 8'((b * 37 + 11) & 127), 1'b0);
            check("R1");
            send(1'b0, 8'(b), 1'b1);
        end

        // R9/R10: data run across the top of the map
        send(1'b0, 8'hF0, 1'b1);
        for (int i = 0; i < 24; i++) begin
            send(1'b1, 8'(i * 29 + 3), 1'b1);
            if (i == 15) check("R10");
        end
        // R3 after writes, then data at home
        send(1'b0, 8'h1A, 1'b1);
        send(1'b1, 8'hC5, 1'b1);

        // R11: garbage without valid
        for (int i = 0; i < 16; i++) begin
            in_valid = 1'b0; in_is_data = i[0]; in_byte = 8'(i * 17 + 1);
            @(negedge clk);
            e_wr = 1'b0;
            check("R11");
        end
        in_byte = 8'h00; in_is_data = 1'b0;

        // R1: reset from a busy state clears everything
        send(1'b0, 8'h3F, 1'b0);
        send(1'b0, 8'h63, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        e_addr = '0; e_disp = '0; e_ps = '0; e_pc = 1'b0; e_set = '0; e_wr = 1'b0;
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule